// File: doc/BRIEF.md
# Receive Byte Queue with Character Timeout

This block buffers the characters produced by a UART receiver. Each character arrives as a single-cycle strobe that carries the byte and three error tags: parity, framing and break. The pair is stored as one queue entry of up to 64. The oldest entry is always presented to the host on the holding-register outputs, so the tags the host sees always describe the byte it is about to take. A host read strobe removes that entry, and the next entry's byte and tags appear on the following cycle.

A data interrupt tells the host that bytes are waiting. In immediate mode it is raised for any stored character. In threshold mode it is raised only once the fill level reaches a programmed trigger. Bytes that sit below the trigger are still delivered through a character-timeout interrupt. The timeout counts oversampling ticks while the queue holds data, and its length follows the configured word length. A character that arrives while the queue is full is discarded and flagged as an overrun.

Top module: `rxq_top`

## Requirements
- R1: The queue stores up to 64 entries, and `rxq_level` reports the number of stored entries (0 to 64).
- R2: While the queue is non-empty, `rhr_data`, `rhr_perr`, `rhr_ferr` and `rhr_brk` show the oldest entry's byte and its own tags. While it is empty, all four read zero.
- R3: A `host_rd` pulse while the queue is non-empty removes the oldest entry, and the next entry with its tags is shown on the following cycle. A `host_rd` pulse while the queue is empty has no effect.
- R4: A `char_valid` pulse while the level is 64 stores nothing and sets `overrun` on the next cycle, even if a read happens in the same cycle. Otherwise `overrun` clears after a read of a non-empty queue.
- R5: With `cfg_thresh_mode` = 0 and `cfg_rx_ie` = 1, `irq_data` is high exactly when the level is at least 1.
- R6: With `cfg_thresh_mode` = 1 and `cfg_rx_ie` = 1, `irq_data` is high exactly when the level is non-zero and at least `cfg_trig`.
- R7: With `cfg_rx_ie` = 0, both `irq_data` and `irq_tmo` stay low.
- R8: `cfg_wlen` values 0, 1, 2 and 3 select word lengths of 5, 6, 7 and 8 bits. The timeout limit is 16 × (4 × word length + 12) ticks. `irq_tmo` rises on the cycle after the tick that completes the limit.
- R9: The timeout count restarts when a character is stored, when the host reads, or while the queue is empty. Ticks do not count while the queue is empty.
- R10: A pending timeout stays pending until a host read of a non-empty queue, and it is clear on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe: a received character is available |
| char_data | input | 8 | Received byte |
| char_perr | input | 1 | Parity error tag of the character |
| char_ferr | input | 1 | Framing error tag of the character |
| char_brk | input | 1 | Break tag of the character |
| host_rd | input | 1 | Host read strobe for the holding register |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| cfg_wlen | input | 2 | Word length code (0 to 3 means 5 to 8 bits) |
| cfg_thresh_mode | input | 1 | 0 = interrupt per character, 1 = interrupt at trigger level |
| cfg_trig | input | 7 | Trigger level for threshold mode |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| rhr_data | output | 8 | Byte at the head of the queue |
| rhr_perr | output | 1 | Parity tag of the head entry |
| rhr_ferr | output | 1 | Framing tag of the head entry |
| rhr_brk | output | 1 | Break tag of the head entry |
| rxq_level | output | 7 | Number of stored entries |
| overrun | output | 1 | A character was dropped because the queue was full |
| irq_data | output | 1 | Data-ready interrupt |
| irq_tmo | output | 1 | Character-timeout interrupt |

## Verification
A behavioural queue model runs in parallel with the block. It is compared with every output on every cycle.

Sparse characters with distinct tag patterns followed by reads show whether the tags stay tied to their bytes. Filling past 64 entries, and reading in the same cycle as a rejected character, separates the overrun priority from the normal pop path. Sweeping the trigger across and exactly onto the fill level tells the two interrupt modes apart.

Long idle stretches with ticks on every cycle, and with ticks on every other cycle, under the shortest and the longest word length, pin down the timeout limit. Characters inserted mid-count show that a new character restarts it. A random mix of characters, reads and ticks covers their interleavings.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // One queue entry: byte plus the three error tags that travel with it
    typedef struct packed {
        logic       brk;
        logic       frm_err;
        logic       par_err;
        logic [7:0] data;
    } rx_ent_t;

    // Timeout length in ticks: (4 words + 12 bits) of bit time
    function automatic int unsigned tmo_ticks(input logic [1:0] wlen,
                                              input int unsigned tpb);
        int unsigned bits;
        bits = 4 * (5 + int'(wlen)) + 12;
        return tpb * bits;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push_req,
    input  rx_ent_t                     push_ent,
    input  logic                        pop_req,
    output rx_ent_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        full,
    output logic                        empty,
    output logic                        push_ok,
    output logic                        pop_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    rx_ent_t           mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  cnt;

    assign full    = (cnt == FULL_LVL);
    assign empty   = (cnt == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign level   = cnt;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4
    no_growth_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req) |=> $stable(level));

    // R3
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !empty && !push_req) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (restart) begin
                cnt <= '0;
            end else if (tick && !flag) begin
                if (cnt >= limit - 1'b1) flag <= 1'b1;
                else                     cnt  <= cnt + 1'b1;
            end
            if (clr) flag <= 1'b0;
        end
    end

    // R8
    tmo_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick));

    // R10
    read_clears_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TPB   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        char_valid,
    input  logic [7:0]                  char_data,
    input  logic                        char_perr,
    input  logic                        char_ferr,
    input  logic                        char_brk,
    input  logic                        host_rd,
    input  logic                        tick16,
    input  logic [1:0]                  cfg_wlen,
    input  logic                        cfg_thresh_mode,
    input  logic [$clog2(DEPTH+1)-1:0]  cfg_trig,
    input  logic                        cfg_rx_ie,
    output logic [7:0]                  rhr_data,
    output logic                        rhr_perr,
    output logic                        rhr_ferr,
    output logic                        rhr_brk,
    output logic [$clog2(DEPTH+1)-1:0]  rxq_level,
    output logic                        overrun,
    output logic                        irq_data,
    output logic                        irq_tmo
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int CNT_W = $clog2(TPB * 44 + 1);

    rx_ent_t          in_ent, head;
    logic [LVL_W-1:0] level;
    logic             full, empty, push_ok, pop_ok, tmo_flag;
    logic [CNT_W-1:0] tmo_limit;

    assign in_ent = '{brk: char_brk, frm_err: char_ferr,
                      par_err: char_perr, data: char_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .push_req(char_valid), .push_ent(in_ent), .pop_req(host_rd),
        .head(head), .level(level), .full(full), .empty(empty),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    assign tmo_limit = CNT_W'(tmo_ticks(cfg_wlen, TPB));

    rxq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst),
        .restart(push_ok || pop_ok || empty),
        .tick(tick16), .clr(pop_ok), .limit(tmo_limit),
        .flag(tmo_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)                     overrun <= 1'b0;
        else if (char_valid && full) overrun <= 1'b1;
        else if (pop_ok)             overrun <= 1'b0;
    end

    assign rhr_data  = head.data;
    assign rhr_perr  = head.par_err;
    assign rhr_ferr  = head.frm_err;
    assign rhr_brk   = head.brk;
    assign rxq_level = level;
    assign irq_data  = cfg_rx_ie && !empty &&
                       (cfg_thresh_mode ? (level >= cfg_trig) : 1'b1);
    assign irq_tmo   = cfg_rx_ie && tmo_flag;

    // R4
    drop_flags_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid && full) |=> overrun);

endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
    logic       host_rd = 1'b0, tick16 = 1'b0;
    logic [1:0] cfg_wlen = 2'd0;
    logic       cfg_thresh_mode = 1'b0;
    logic [6:0] cfg_trig = 7'd1;
    logic       cfg_rx_ie = 1'b1;
    logic [7:0] rhr_data;
    logic       rhr_perr, rhr_ferr, rhr_brk;
    logic [6:0] rxq_level;
    logic       overrun, irq_data, irq_tmo;

    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    rxq_top dut (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
        .host_rd(host_rd), .tick16(tick16), .cfg_wlen(cfg_wlen),
        .cfg_thresh_mode(cfg_thresh_mode), .cfg_trig(cfg_trig),
        .cfg_rx_ie(cfg_rx_ie), .rhr_data(rhr_data), .rhr_perr(rhr_perr),
        .rhr_ferr(rhr_ferr), .rhr_brk(rhr_brk), .rxq_level(rxq_level),
        .overrun(overrun), .irq_data(irq_data), .irq_tmo(irq_tmo)
    );

    // Reference model: entries are {brk, ferr, perr, data}
    logic [10:0] q[$];
    int          tcnt = 0;
    bit          tflag = 0, ovr = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); tcnt = 0; tflag = 0; ovr = 0;
        end else begin
            bit is_full, is_empty, pop, push;
            int lim;
            is_full  = (q.size() == 64);
            is_empty = (q.size() == 0);
            pop  = host_rd && !is_empty;
            push = char_valid && !is_full;
            lim  = 16 * (4 * (5 + int'(cfg_wlen)) + 12);
            if (push || pop || is_empty) tcnt = 0;
            else if (tick16 && !tflag) begin
                if (tcnt >= lim - 1) tflag = 1;
                else tcnt++;
            end
            if (pop) tflag = 0;
            if (char_valid && is_full) ovr = 1;
            else if (pop) ovr = 0;
            if (pop) void'(q.pop_front());
            if (push) q.push_back({char_brk, char_ferr, char_perr, char_data});
        end
    end

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int  hexp, lvl;
        bit  dexp;
        lvl  = q.size();
        hexp = (lvl != 0) ? int'(q[0]) : 0;
        dexp = cfg_rx_ie && lvl > 0 && (cfg_thresh_mode ? (lvl >= int'(cfg_trig)) : 1'b1);
        chk("R2/R3 head entry", int'({rhr_brk, rhr_ferr, rhr_perr, rhr_data}), hexp);
        chk("R1 level", int'(rxq_level), lvl);
        chk("R4 overrun", int'(overrun), int'(ovr));
        if (!cfg_rx_ie)           chk("R7 irq_data", int'(irq_data), int'(dexp));
        else if (cfg_thresh_mode) chk("R6 irq_data", int'(irq_data), int'(dexp));
        else                      chk("R5 irq_data", int'(irq_data), int'(dexp));
        chk("R8/R9/R10 irq_tmo", int'(irq_tmo), int'(tflag && cfg_rx_ie));
    endtask

    // One cycle: check outputs at the falling edge, then drive new inputs
    task automatic cyc(bit cv, logic [10:0] ent, bit rd, bit tk);
        @(negedge clk);
        compare_all();
        char_valid = cv;
        {char_brk, char_ferr, char_perr, char_data} = ent;
        host_rd = rd;
        tick16  = tk;
    endtask

    task automatic idle(int n, bit tk);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, tk);
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset/empty state, then sparse characters with distinct tags
        cyc(1, {3'b001, 8'hA5}, 0, 0);
        cyc(0, '0, 0, 0);
        cyc(1, {3'b010, 8'h3C}, 0, 0);
        cyc(1, {3'b100, 8'hFF}, 0, 0);
        idle(2, 0);
        // R3 reads advance the head; read on empty ignored
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0);
        cyc(1, {3'b111, 8'h11}, 1, 0);   // empty: push and ignored read
        cyc(1, {3'b000, 8'h22}, 1, 0);   // simultaneous push and pop
        idle(2, 0);
        cyc(0, '0, 1, 0);
        idle(2, 0);
        // R1 R4 fill past 64
        for (int i = 0; i < 66; i++) cyc(1, {i[2:0], i[7:0]}, 0, 0);
        idle(2, 0);
        cyc(1, {3'b011, 8'h77}, 1, 0);   // drop wins over read
        idle(2, 0);
        cyc(0, '0, 1, 0);                // read clears overrun
        idle(2, 0);
        for (int i = 0; i < 70; i++) cyc(i % 3 == 0, {3'b101, i[7:0]}, 1, 0);
        idle(2, 0);
        // R6 threshold mode, trigger swept across level
        cfg_thresh_mode = 1'b1;
        cfg_trig = 7'd4;
        for (int i = 0; i < 6; i++) cyc(1, {3'b000, 8'(8'h40 + i)}, 0, 0);
        idle(1, 0);
        for (int t = 0; t < 8; t++) begin
            cfg_trig = 7'(t);
            idle(1, 0);
        end
        cfg_trig = 7'd64;
        idle(1, 0);
        // R7 enable off
        cfg_rx_ie = 1'b0;
        idle(2, 0);
        cfg_rx_ie = 1'b1;
        for (int i = 0; i < 6; i++) cyc(0, '0, 1, 0);
        idle(2, 0);
        // R8 R9 R10 timeout, shortest word, tick every cycle
        cfg_thresh_mode = 1'b0;
        cfg_wlen = 2'd0;
        cyc(1, {3'b000, 8'h5A}, 0, 1);
        cyc(1, {3'b000, 8'h5B}, 0, 1);
        idle(600, 1);
        cfg_rx_ie = 1'b0;
        idle(2, 1);
        cfg_rx_ie = 1'b1;
        cyc(0, '0, 1, 1);
        idle(600, 1);
        cyc(0, '0, 1, 1);
        idle(700, 1);                    // empty: no timeout
        // R8 R9 longest word, tick every other cycle, restart mid-count
        cfg_wlen = 2'd3;
        cyc(1, {3'b000, 8'h61}, 0, 0);
        for (int i = 0; i < 800; i++) cyc(0, '0, 0, i[0]);
        cyc(1, {3'b000, 8'h62}, 0, 1);
        for (int i = 0; i < 1500; i++) cyc(0, '0, 0, i[0]);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 1, 0);
        idle(3, 1);
        // Random mix over all modes
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) begin
                cfg_wlen        = 2'($urandom_range(0, 3));
                cfg_thresh_mode = 1'($urandom_range(0, 1));
                cfg_trig        = 7'($urandom_range(0, 64));
            end
            cyc($urandom_range(0, 99) < 40, 11'($urandom),
                $urandom_range(0, 99) < 30, $urandom_range(0, 3) == 0);
        end
        idle(2, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule